// File: doc/BRIEF.md
# Decoded One-Hot Select Multiplexer

This block picks one of several equal-width data words using a separate enable line per word rather than a binary index. Every data word has its own select bit; the word whose bit is high appears on the output. When every select bit is low, a default word fixed at elaboration time is driven instead. The block holds no state and has no clock: the output follows the inputs within the same time step.

The datapath is a pure AND-OR structure. Each word is masked by its own select bit, the default word is masked by a "nothing selected" term, and the masked words are ORed together through a balanced tree. The word count and data width are parameters, and a single-input build is legal. The upstream logic must keep the select lines one-hot or all low; a checker bound to the block reports any cycle where two or more are high.

Top module: `onehot_select_mux`

## Requirements
- R1: When select bit k alone is high, the output equals data word k, where word k occupies bits [k*DATA_W +: DATA_W] of the packed data input.
- R2: When all select bits are low, the output equals the DFLT parameter (all zeros unless overridden).
- R3: Data words whose select bit is low have no effect on the output; changing them while the select is held leaves the output unchanged.
- R4: At most one select bit is high at a time; two or more high is an illegal input flagged by an assertion.
- R5: The output is combinational: it reflects new inputs in the same time step with no clock edge.
- R6: A build with one input and a non-zero default works: select high gives the single word, select low gives the default.
- R7: Select bit ordering is positional: bit 0 picks the lowest word and bit N_IN-1 the highest, with no priority between bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_data | input | N_IN*DATA_W | Packed data words, word k in bits [k*DATA_W +: DATA_W] |
| in_sel | input | N_IN | One enable bit per data word, bit k enables word k |
| out_data | output | DATA_W | Selected word, or DFLT when no enable is high |

## Verification
The assertions assume the select vector is never multi-hot; under that assumption the output must be exactly the enabled word or the default, and no bit may come from a masked word. The stimulus keeps within this by building each select value either as all zeros or as a single bit at a random position, so the illegal case is never driven. Directed cases cover the two end positions, the idle vector, held-select data changes, and a one-input build with a non-zero default.

// File: rtl/ohmux_pkg.sv
package ohmux_pkg;

    // Smallest power of two that is at least n (n >= 1).
    function automatic int pow2_ceil(input int n);
        int p;
        p = 1;
        while (p < n) p = p * 2;
        return p;
    endfunction

endpackage

// File: rtl/ohmux_lane_gate.sv
module ohmux_lane_gate #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              en_i,
    output logic [DATA_W-1:0] word_o
);

    always_comb begin
        word_o = word_i & {DATA_W{en_i}};
    end

endmodule

// File: rtl/ohmux_or_tree.sv
module ohmux_or_tree #(
    parameter int DATA_W = 8,
    parameter int N_LEAF = 5
) (
    input  logic [N_LEAF*DATA_W-1:0] leaf_i,
    output logic [DATA_W-1:0]        root_o
);

    localparam int P = ohmux_pkg::pow2_ceil(N_LEAF);

    // Heap layout: node 1 is the root, leaves sit at P .. 2P-1.
    logic [DATA_W-1:0] node [1:2*P-1];

    genvar gi;
    generate
        for (gi = 0; gi < P; gi++) begin : g_leaf
            if (gi < N_LEAF) begin : g_real
                assign node[P+gi] = leaf_i[gi*DATA_W +: DATA_W];
            end else begin : g_pad
                assign node[P+gi] = '0;
            end
        end
        for (gi = 1; gi < P; gi++) begin : g_inner
            assign node[gi] = node[2*gi] | node[2*gi+1];
        end
    endgenerate

    assign root_o = node[1];

endmodule

// File: rtl/onehot_select_mux.sv
module onehot_select_mux #(
    parameter int                DATA_W = 8,
    parameter int                N_IN   = 4,
    parameter logic [DATA_W-1:0] DFLT   = '0
) (
    input  logic [N_IN*DATA_W-1:0] in_data,
    input  logic [N_IN-1:0]        in_sel,
    output logic [DATA_W-1:0]      out_data
);

    // The default word is one extra lane enabled when no select is high.
    localparam int N_LANE = N_IN + 1;

    logic [N_LANE*DATA_W-1:0] masked;
    logic                     idle;

    always_comb begin
        idle = ~|in_sel;
    end

    genvar gk;
    generate
        for (gk = 0; gk < N_IN; gk++) begin : g_lane
            ohmux_lane_gate #(.DATA_W(DATA_W)) u_gate (
                .word_i (in_data[gk*DATA_W +: DATA_W]),
                .en_i   (in_sel[gk]),
                .word_o (masked[gk*DATA_W +: DATA_W])
            );
        end
    endgenerate

    ohmux_lane_gate #(.DATA_W(DATA_W)) u_dflt_gate (
        .word_i (DFLT),
        .en_i   (idle),
        .word_o (masked[N_IN*DATA_W +: DATA_W])
    );

    ohmux_or_tree #(.DATA_W(DATA_W), .N_LEAF(N_LANE)) u_tree (
        .leaf_i (masked),
        .root_o (out_data)
    );

endmodule

// File: rtl/ohmux_chk.sv
module ohmux_chk #(
    parameter int                DATA_W = 8,
    parameter int                N_IN   = 4,
    parameter logic [DATA_W-1:0] DFLT   = '0
) (
    input logic [N_IN*DATA_W-1:0] in_data,
    input logic [N_IN-1:0]        in_sel,
    input logic [DATA_W-1:0]      out_data
);

    always_comb begin
        // R4: select vector never multi-hot
        assert_sel_onehot0_R4: assert ($onehot0(in_sel));
    end

    always_comb begin
        // R2 / R6: idle selects give the default word
        if (in_sel == '0) begin
            assert_idle_default_R2: assert (out_data == DFLT);
        end
    end

    always_comb begin
        // R1 / R7: a lone select bit k routes word k
        for (int k = 0; k < N_IN; k++) begin
            logic [N_IN-1:0] hot;
            hot = '0;
            hot[k] = 1'b1;
            if (in_sel == hot) begin
                assert_pick_lane_R1: assert (out_data == in_data[k*DATA_W +: DATA_W]);
            end
        end
    end

    always_comb begin
        // R3: no output bit may come from a masked word
        logic [DATA_W-1:0] allowed;
        allowed = (in_sel == '0) ? DFLT : '0;
        for (int k = 0; k < N_IN; k++) begin
            if (in_sel[k]) allowed = allowed | in_data[k*DATA_W +: DATA_W];
        end
        assert_no_masked_bits_R3: assert ((out_data & ~allowed) == '0);
    end

endmodule

bind onehot_select_mux ohmux_chk #(
    .DATA_W (DATA_W),
    .N_IN   (N_IN),
    .DFLT   (DFLT)
) u_chk (
    .in_data  (in_data),
    .in_sel   (in_sel),
    .out_data (out_data)
);

// File: tb/tb_onehot_select_mux.sv
`timescale 1ns/1ps
module tb_onehot_select_mux;

    localparam int W  = 8;
    localparam int N  = 4;
    localparam int W1 = 12;
    localparam logic [W1-1:0] D1 = 12'hA5C;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [N*W-1:0] in_data;
    logic [N-1:0]   in_sel;
    logic [W-1:0]   out_data;

    logic [W1-1:0]  s_data;
    logic           s_sel;
    logic [W1-1:0]  s_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    onehot_select_mux #(.DATA_W(W), .N_IN(N)) dut (
        .in_data (in_data), .in_sel (in_sel), .out_data (out_data)
    );

    onehot_select_mux #(.DATA_W(W1), .N_IN(1), .DFLT(D1)) dut_one (
        .in_data (s_data), .in_sel (s_sel), .out_data (s_out)
    );

    function automatic logic [W-1:0] model(input logic [N*W-1:0] d, input logic [N-1:0] s);
        logic [W-1:0] r;
        r = '0;
        for (int k = 0; k < N; k++) if (s[k]) r = d[k*W +: W];
        return r;
    endfunction

    task automatic check(input string req, input logic [W1-1:0] act, input logic [W1-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [N*W-1:0] d, input logic [N-1:0] s);
        @(negedge clk);
        in_data = d;
        in_sel  = s;
        #1;
    endtask

    function automatic logic [N*W-1:0] rnd_data();
        logic [N*W-1:0] v;
        for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom);
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] d;
        logic [N-1:0]   s;
        void'($urandom(32'h1234_5678));
        in_data = '0; in_sel = '0; s_data = '0; s_sel = 1'b0;
        #2;
        // Initial idle state: default of zero (R2)
        check("R2 idle start", W1'(out_data), W1'(8'h00));

        // R2: idle with busy data
        apply({8'hFF, 8'hEE, 8'hDD, 8'hCC}, 4'b0000);
        check("R2 idle busy data", W1'(out_data), W1'(8'h00));

        // R7 / R1: end positions and order
        apply({8'h44, 8'h33, 8'h22, 8'h11}, 4'b0001);
        check("R7 bit0 lowest word", W1'(out_data), W1'(8'h11));
        apply({8'h44, 8'h33, 8'h22, 8'h11}, 4'b1000);
        check("R7 top bit highest word", W1'(out_data), W1'(8'h44));
        apply({8'h44, 8'h33, 8'h22, 8'h11}, 4'b0100);
        check("R1 middle word", W1'(out_data), W1'(8'h33));

        // R3: hold select, change masked words
        apply({8'h00, 8'h00, 8'h5A, 8'h00}, 4'b0010);
        check("R3 before", W1'(out_data), W1'(8'h5A));
        apply({8'hFF, 8'hFF, 8'h5A, 8'hFF}, 4'b0010);
        check("R3 masked words changed", W1'(out_data), W1'(8'h5A));

        // R5: output tracks input without a clock edge
        @(negedge clk);
        in_sel = 4'b0001;
        in_data = {8'h01, 8'h02, 8'h03, 8'h7E};
        #1;
        check("R5 same-step response", W1'(out_data), W1'(8'h7E));
        in_sel = 4'b0000;
        #1;
        check("R5 drop to default", W1'(out_data), W1'(8'h00));

        // R6: single-input build with non-zero default
        s_data = 12'h3C1; s_sel = 1'b0; #1;
        check("R6 one-input default", s_out, D1);
        s_sel = 1'b1; #1;
        check("R6 one-input selected", s_out, 12'h3C1);
        s_data = 12'h000; #1;
        check("R6 one-input zero word", s_out, 12'h000);

        // Random: one-hot or idle selects (R1, R2, R3)
        for (int it = 0; it < 400; it++) begin
            d = rnd_data();
            s = '0;
            if ($urandom_range(4) != 0) s[$urandom_range(N-1)] = 1'b1;
            apply(d, s);
            check(s == '0 ? "R2 random idle" : "R1 random pick", W1'(out_data), W1'(model(d, s)));
            if (s != '0) begin
                logic [N*W-1:0] d2;
                d2 = rnd_data();
                for (int k = 0; k < N; k++) if (s[k]) d2[k*W +: W] = d[k*W +: W];
                apply(d2, s);
                check("R3 random masked change", W1'(out_data), W1'(model(d, s)));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule